// File: doc/BRIEF.md
# Flash Block Protection Unit

This unit sits between a flash command decoder and the storage array and decides, one request at a time, whether a read, a program or an erase may reach the array. It decodes a 24-bit byte address into the protection region that contains it. It keeps a lock bank with one write-lock bit per region and one read-lock bit per small parameter block. It answers each request one clock later with a grant or a violation. A read that is refused returns all ones on the data path in place of the array word.

The regions are not uniform. The lowest and the highest 64 KiB of the address space are each split into four 8 KiB parameter blocks and one 32 KiB parameter block. The low end places the four small blocks at the bottom, and the high end places them at the top. Everything in between is a run of 64 KiB main blocks. Only the small parameter blocks carry a read lock. The 32 KiB blocks and the main blocks carry a write lock only. Lock bits are set through an update port that addresses a region by any byte inside it. A single lock-down pulse freezes the whole lock bank until the next reset.

Top module: `fbp_guard`

## Requirements
- R1: Region map, with offsets relative to the containing 64 KiB block. In block 0, offsets 0x0000-0x7FFF form small blocks 0-3, 8 KiB each, in address order, and 0x8000-0xFFFF form the low 32 KiB block. In the highest block, 0x0000-0x7FFF form the high 32 KiB block and 0x8000-0xFFFF form small blocks 4-7. Every other 64 KiB block is one main region.
- R2: After reset every lock bit and the lock-down state are clear, so every request of every kind is granted.
- R3: A request presented with req_valid_i high is answered exactly one clock later with rsp_valid_o high and exactly one of rsp_grant_o and rsp_viol_o high. In a cycle that follows no request, all three outputs are low.
- R4: A read (op 0) that falls in a read-locked small block is refused, and rd_data_o is all ones in the response cycle. A granted read passes arr_rdata_i to rd_data_o unchanged.
- R5: Each small block's read lock and write lock are independent. A read lock does not refuse program or erase, and a write lock does not refuse reads. Locks on one small block do not affect its neighbours.
- R6: The 32 KiB blocks and the main blocks have no read lock. The upd_rd_lock_i value is ignored when updating them, and reads there are always granted.
- R7: A program (op 1) or a sector erase (op 2) is refused when the region holding the address is write locked.
- R8: A block erase (op 3) is refused when any region inside the containing 64 KiB block is write locked. For the two end blocks this covers all five parameter regions.
- R9: An update with upd_valid_i high loads the region selected by upd_addr_i with the given lock values at the clock edge. A request in the same cycle is judged against the previous values, and a request in the next cycle is judged against the new ones. Clearing a lock is allowed.
- R10: A pulse on lkdn_set_i makes every later update have no effect. Only reset clears the lock-down state, and reset also clears all locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_valid_i | input | 1 | Lock update strobe |
| upd_addr_i | input | 24 | Any byte address inside the region to update |
| upd_rd_lock_i | input | 1 | New read-lock value (small blocks only) |
| upd_wr_lock_i | input | 1 | New write-lock value |
| lkdn_set_i | input | 1 | Lock-down request, sticky until reset |
| req_valid_i | input | 1 | Access request strobe |
| req_op_i | input | 2 | 0 read, 1 program, 2 sector erase, 3 block erase |
| req_addr_i | input | 24 | Byte address of the access |
| arr_rdata_i | input | 32 | Word from the array in the response cycle |
| rsp_valid_o | output | 1 | Response present |
| rsp_grant_o | output | 1 | Access allowed |
| rsp_viol_o | output | 1 | Access refused |
| rd_data_o | output | 32 | Read data, all ones after a refused read |

## Verification
The bench walks the boundaries between small blocks, between the 32 KiB blocks and their small neighbours, and between the end blocks and the main array. A decoder off by one region there would grant or refuse on the wrong side of a boundary. It locks a single small block and then erases a whole end block. A design that looked only at the addressed region would wrongly grant that erase. It sets a read lock on a 32 KiB block and on a main block and reads them; a design that stored those bits would refuse the reads. It also issues a request in the same cycle as an update, and it tries updates after lock-down. A design that forwarded updates early, or did not freeze the lock bank, would give grants that differ from the reference model.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   typedef enum logic [1:0] {
      OP_READ       = 2'd0,
      OP_PROG       = 2'd1,
      OP_SECT_ERASE = 2'd2,
      OP_BLK_ERASE  = 2'd3
   } fbp_op_e;

   typedef enum logic [1:0] {
      RK_SMALL = 2'd0,
      RK_BIG   = 2'd1,
      RK_MAIN  = 2'd2
   } fbp_kind_e;

endpackage

// File: rtl/fbp_region_decode.sv
module fbp_region_decode
   import fbp_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int MAIN_KB   = 64,
   parameter int SMALL_KB  = 8,
   parameter int BIG_KB    = 32,
   parameter int NUM_SMALL = 4,
   localparam int BLK_W    = $clog2(MAIN_KB * 1024),
   localparam int MIDX_W   = ADDR_W - BLK_W,
   localparam int SIDX_W   = $clog2(2 * NUM_SMALL)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output fbp_kind_e         kind_o,
   output logic [SIDX_W-1:0] sidx_o,
   output logic              top_o,
   output logic [MIDX_W-1:0] midx_o
);

   localparam int SMALL_B    = SMALL_KB * 1024;
   localparam int BIG_B      = BIG_KB * 1024;
   localparam int SMALL_W    = $clog2(SMALL_B);
   localparam int SMALL_SPAN = NUM_SMALL * SMALL_B;

   logic [MIDX_W-1:0] blk;
   logic [BLK_W-1:0]  off;
   logic [BLK_W-1:0]  rel;
   logic              is_bot;
   logic              is_top;

   assign blk    = addr_i[ADDR_W-1:BLK_W];
   assign off    = addr_i[BLK_W-1:0];
   assign is_bot = (blk == '0);
   assign is_top = (blk == '1);

   assign top_o  = is_top;
   assign midx_o = blk - MIDX_W'(1);

   always_comb begin
      kind_o = RK_MAIN;
      rel    = '0;
      if (is_bot) begin
         if (off < BLK_W'(SMALL_SPAN)) begin
            kind_o = RK_SMALL;
            rel    = off;
         end else begin
            kind_o = RK_BIG;
         end
      end else if (is_top) begin
         if (off < BLK_W'(BIG_B)) begin
            kind_o = RK_BIG;
         end else begin
            kind_o = RK_SMALL;
            rel    = (off - BLK_W'(BIG_B)) + BLK_W'(SMALL_SPAN);
         end
      end
   end

   assign sidx_o = SIDX_W'(rel >> SMALL_W);

endmodule

// File: rtl/fbp_lock_bank.sv
module fbp_lock_bank
   import fbp_pkg::*;
#(
   parameter int NUM_SMALL = 4,
   parameter int MIDX_W    = 8,
   localparam int NSM      = 2 * NUM_SMALL,
   localparam int SIDX_W   = $clog2(NSM),
   localparam int NMAIN    = (1 << MIDX_W) - 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              upd_en_i,
   input  fbp_kind_e         upd_kind_i,
   input  logic [SIDX_W-1:0] upd_sidx_i,
   input  logic              upd_top_i,
   input  logic [MIDX_W-1:0] upd_midx_i,
   input  logic              upd_rd_i,
   input  logic              upd_wr_i,
   input  logic              lkdn_set_i,
   input  fbp_kind_e         look_kind_i,
   input  logic [SIDX_W-1:0] look_sidx_i,
   input  logic              look_top_i,
   input  logic [MIDX_W-1:0] look_midx_i,
   output logic              rd_lk_o,
   output logic              wr_lk_o,
   output logic              blk_any_wr_o
);

   logic [NSM-1:0]   small_rd_q, small_wr_q, small_hit;
   logic [1:0]       big_wr_q, big_hit;
   logic [NMAIN-1:0] main_wr_q, main_hit;
   logic             lkdn_q;
   logic             upd_ok;
   logic [1:0]       end_any;

   assign upd_ok = upd_en_i && !lkdn_q;

   for (genvar i = 0; i < NSM; i++) begin : g_small_hit
      assign small_hit[i] = upd_ok && (upd_kind_i == RK_SMALL) &&
                            (upd_sidx_i == SIDX_W'(i));
   end

   for (genvar b = 0; b < 2; b++) begin : g_big_hit
      assign big_hit[b] = upd_ok && (upd_kind_i == RK_BIG) &&
                          (upd_top_i == 1'(b));
      assign end_any[b] = |small_wr_q[b*NUM_SMALL +: NUM_SMALL] | big_wr_q[b];
   end

   for (genvar m = 0; m < NMAIN; m++) begin : g_main_hit
      assign main_hit[m] = upd_ok && (upd_kind_i == RK_MAIN) &&
                           (upd_midx_i == MIDX_W'(m));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         small_rd_q <= '0;
         small_wr_q <= '0;
         big_wr_q   <= '0;
         main_wr_q  <= '0;
         lkdn_q     <= 1'b0;
      end else begin
         small_rd_q <= (small_rd_q & ~small_hit) | (small_hit & {NSM{upd_rd_i}});
         small_wr_q <= (small_wr_q & ~small_hit) | (small_hit & {NSM{upd_wr_i}});
         big_wr_q   <= (big_wr_q & ~big_hit) | (big_hit & {2{upd_wr_i}});
         main_wr_q  <= (main_wr_q & ~main_hit) | (main_hit & {NMAIN{upd_wr_i}});
         if (lkdn_set_i) lkdn_q <= 1'b1;
      end
   end

   always_comb begin
      rd_lk_o      = 1'b0;
      wr_lk_o      = 1'b0;
      blk_any_wr_o = 1'b0;
      unique case (look_kind_i)
         RK_SMALL: begin
            rd_lk_o      = small_rd_q[look_sidx_i];
            wr_lk_o      = small_wr_q[look_sidx_i];
            blk_any_wr_o = end_any[look_top_i];
         end
         RK_BIG: begin
            wr_lk_o      = big_wr_q[look_top_i];
            blk_any_wr_o = end_any[look_top_i];
         end
         default: begin
            wr_lk_o      = main_wr_q[look_midx_i];
            blk_any_wr_o = main_wr_q[look_midx_i];
         end
      endcase
   end

   // R10: a frozen bank never changes
   p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lkdn_q |=> ($stable(small_rd_q) && $stable(small_wr_q) &&
                  $stable(big_wr_q) && $stable(main_wr_q)));

   // R10: lock-down stays set until reset
   p_lkdn_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lkdn_q |=> lkdn_q);

endmodule

// File: rtl/fbp_access_check.sv
module fbp_access_check
   import fbp_pkg::*;
(
   input  fbp_op_e op_i,
   input  logic    rd_lk_i,
   input  logic    wr_lk_i,
   input  logic    blk_any_wr_i,
   output logic    allow_o
);

   always_comb begin
      unique case (op_i)
         OP_READ:       allow_o = !rd_lk_i;
         OP_PROG,
         OP_SECT_ERASE: allow_o = !wr_lk_i;
         default:       allow_o = !blk_any_wr_i;
      endcase
   end

endmodule

// File: rtl/fbp_guard.sv
module fbp_guard
   import fbp_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 32,
   parameter int MAIN_KB   = 64,
   parameter int SMALL_KB  = 8,
   parameter int BIG_KB    = 32,
   parameter int NUM_SMALL = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              upd_valid_i,
   input  logic [ADDR_W-1:0] upd_addr_i,
   input  logic              upd_rd_lock_i,
   input  logic              upd_wr_lock_i,
   input  logic              lkdn_set_i,
   input  logic              req_valid_i,
   input  logic [1:0]        req_op_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] arr_rdata_i,
   output logic              rsp_valid_o,
   output logic              rsp_grant_o,
   output logic              rsp_viol_o,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int BLK_W  = $clog2(MAIN_KB * 1024);
   localparam int MIDX_W = ADDR_W - BLK_W;
   localparam int SIDX_W = $clog2(2 * NUM_SMALL);

   if (NUM_SMALL * SMALL_KB + BIG_KB != MAIN_KB) begin : g_bad_split
      $error("parameter blocks must fill exactly one main block");
   end
   if ((1 << $clog2(SMALL_KB)) != SMALL_KB || (1 << $clog2(MAIN_KB)) != MAIN_KB) begin : g_bad_pow2
      $error("block sizes must be powers of two");
   end
   if (MIDX_W < 2) begin : g_bad_addr
      $error("address space must hold at least two main blocks");
   end

   fbp_kind_e         u_kind, r_kind;
   logic [SIDX_W-1:0] u_sidx, r_sidx;
   logic              u_top, r_top;
   logic [MIDX_W-1:0] u_midx, r_midx;
   logic              rd_lk, wr_lk, blk_any, allow;
   fbp_op_e           req_op;

   logic rsp_valid_q, rsp_grant_q, rsp_rdfill_q;

   assign req_op = fbp_op_e'(req_op_i);

   fbp_region_decode #(
      .ADDR_W(ADDR_W), .MAIN_KB(MAIN_KB), .SMALL_KB(SMALL_KB),
      .BIG_KB(BIG_KB), .NUM_SMALL(NUM_SMALL)
   ) u_dec_upd (
      .addr_i(upd_addr_i), .kind_o(u_kind), .sidx_o(u_sidx),
      .top_o(u_top), .midx_o(u_midx)
   );

   fbp_region_decode #(
      .ADDR_W(ADDR_W), .MAIN_KB(MAIN_KB), .SMALL_KB(SMALL_KB),
      .BIG_KB(BIG_KB), .NUM_SMALL(NUM_SMALL)
   ) u_dec_req (
      .addr_i(req_addr_i), .kind_o(r_kind), .sidx_o(r_sidx),
      .top_o(r_top), .midx_o(r_midx)
   );

   fbp_lock_bank #(
      .NUM_SMALL(NUM_SMALL), .MIDX_W(MIDX_W)
   ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .upd_en_i(upd_valid_i), .upd_kind_i(u_kind), .upd_sidx_i(u_sidx),
      .upd_top_i(u_top), .upd_midx_i(u_midx),
      .upd_rd_i(upd_rd_lock_i), .upd_wr_i(upd_wr_lock_i),
      .lkdn_set_i(lkdn_set_i),
      .look_kind_i(r_kind), .look_sidx_i(r_sidx), .look_top_i(r_top),
      .look_midx_i(r_midx),
      .rd_lk_o(rd_lk), .wr_lk_o(wr_lk), .blk_any_wr_o(blk_any)
   );

   fbp_access_check u_chk (
      .op_i(req_op), .rd_lk_i(rd_lk), .wr_lk_i(wr_lk),
      .blk_any_wr_i(blk_any), .allow_o(allow)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_q  <= 1'b0;
         rsp_grant_q  <= 1'b0;
         rsp_rdfill_q <= 1'b0;
      end else begin
         rsp_valid_q  <= req_valid_i;
         rsp_grant_q  <= req_valid_i && allow;
         rsp_rdfill_q <= req_valid_i && !allow && (req_op == OP_READ);
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_grant_o = rsp_grant_q;
   assign rsp_viol_o  = rsp_valid_q && !rsp_grant_q;
   assign rd_data_o   = rsp_rdfill_q ? {DATA_W{1'b1}} : arr_rdata_i;

   // R3: every request gets a response on the next edge
   p_rsp_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> (rsp_valid_o && (rsp_grant_o != rsp_viol_o)));

   // R3: quiet outputs after an idle cycle
   p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> (!rsp_valid_o && !rsp_grant_o && !rsp_viol_o));

   // R4: read into a read-locked block returns all ones
   p_read_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op == OP_READ && rd_lk) |=> (rsp_viol_o && rd_data_o == '1));

   // R6: reads outside small blocks are never refused
   p_open_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op == OP_READ && r_kind != RK_SMALL) |=> rsp_grant_o);

   // R8: a write lock on the addressed region also stops a block erase
   p_blk_erase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op == OP_BLK_ERASE && wr_lk) |=> rsp_viol_o);

endmodule

// File: tb/sim_fbp_guard.sv
`timescale 1ns/1ps
module sim_fbp_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic [23:0] upd_addr = '0;
   logic        upd_rd = 1'b0, upd_wr = 1'b0, lkdn = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [23:0] req_addr = '0;
   logic [31:0] arr_rdata = '0;
   logic        rsp_valid, rsp_grant, rsp_viol;
   logic [31:0] rd_data;

   always #4 clk = ~clk;

   fbp_guard u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .upd_valid_i(upd_valid), .upd_addr_i(upd_addr),
      .upd_rd_lock_i(upd_rd), .upd_wr_lock_i(upd_wr), .lkdn_set_i(lkdn),
      .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
      .arr_rdata_i(arr_rdata),
      .rsp_valid_o(rsp_valid), .rsp_grant_o(rsp_grant), .rsp_viol_o(rsp_viol),
      .rd_data_o(rd_data)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state
   bit srd[8], swr[8], bwr[2], mwr[256];
   bit lkd;
   bit exp_v, exp_g, exp_fill;
   string pend_tag = "R2";

   function automatic void where(input logic [23:0] a, output int kind, output int idx);
      int blk = int'(a[23:16]);
      int off = int'(a[15:0]);
      if (blk == 0) begin
         if (off < 'h8000) begin kind = 0; idx = off / 'h2000; end
         else begin kind = 1; idx = 0; end
      end else if (blk == 255) begin
         if (off < 'h8000) begin kind = 1; idx = 1; end
         else begin kind = 0; idx = 4 + (off - 'h8000) / 'h2000; end
      end else begin
         kind = 2; idx = blk;
      end
   endfunction

   function automatic bit allowed(input logic [1:0] op, input logic [23:0] a);
      int kind, idx, blk;
      where(a, kind, idx);
      blk = int'(a[23:16]);
      case (op)
         2'd0: return !(kind == 0 && srd[idx]);
         2'd1, 2'd2: begin
            if (kind == 0) return !swr[idx];
            if (kind == 1) return !bwr[idx];
            return !mwr[idx];
         end
         default: begin
            if (blk == 0) return !(swr[0] | swr[1] | swr[2] | swr[3] | bwr[0]);
            if (blk == 255) return !(swr[4] | swr[5] | swr[6] | swr[7] | bwr[1]);
            return !mwr[blk];
         end
      endcase
   endfunction

   task automatic model_clear();
      foreach (srd[i]) begin srd[i] = 0; swr[i] = 0; end
      bwr[0] = 0; bwr[1] = 0;
      foreach (mwr[i]) mwr[i] = 0;
      lkd = 0;
   endtask

   task automatic compare();
      logic [31:0] ed;
      ed = exp_fill ? 32'hFFFF_FFFF : arr_rdata;
      n_checks++;
      if (rsp_valid !== exp_v || rsp_grant !== (exp_v & exp_g) ||
          rsp_viol !== (exp_v & !exp_g) || rd_data !== ed) begin
         n_fail++;
         $display("FAIL %s: got v=%b g=%b x=%b d=%h, expected v=%b g=%b x=%b d=%h",
                  pend_tag, rsp_valid, rsp_grant, rsp_viol, rd_data,
                  exp_v, exp_v & exp_g, exp_v & !exp_g, ed);
      end
   endtask

   task automatic step(input bit uv, input logic [23:0] ua, input bit urd, input bit uwr,
                       input bit lk, input bit rv, input logic [1:0] op,
                       input logic [23:0] ra, input string tag);
      int kind, idx;
      @(negedge clk);
      compare();
      upd_valid = uv; upd_addr = ua; upd_rd = urd; upd_wr = uwr; lkdn = lk;
      req_valid = rv; req_op = op; req_addr = ra; arr_rdata = $urandom;
      exp_v = rv;
      exp_g = allowed(op, ra);
      exp_fill = rv && !exp_g && (op == 2'd0);
      if (uv && !lkd) begin
         where(ua, kind, idx);
         if (kind == 0) begin srd[idx] = urd; swr[idx] = uwr; end
         else if (kind == 1) bwr[idx] = uwr;
         else mwr[idx] = uwr;
      end
      if (lk) lkd = 1;
      pend_tag = tag;
   endtask

   task automatic req(input logic [1:0] op, input logic [23:0] a, input string tag);
      step(0, '0, 0, 0, 0, 1, op, a, tag);
   endtask

   task automatic upd(input logic [23:0] a, input bit r, input bit w, input string tag);
      step(1, a, r, w, 0, 0, 2'd0, '0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      upd_valid = 0; lkdn = 0; req_valid = 0;
      model_clear();
      exp_v = 0; exp_g = 0; exp_fill = 0;
      pend_tag = "R2";
      repeat (2) begin @(negedge clk); compare(); end
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      model_clear();
      exp_v = 0; exp_g = 0; exp_fill = 0;
      do_reset();
      // R2: everything open after reset
      req(2'd0, 24'h000000, "R2");
      req(2'd1, 24'h009000, "R2");
      req(2'd3, 24'hFF0000, "R2");
      req(2'd2, 24'h123456, "R2");
      step(0, '0, 0, 0, 0, 0, 2'd0, '0, "R3");   // idle response
      step(0, '0, 0, 0, 0, 0, 2'd0, '0, "R3");
      // R4/R5: read lock on small block 1
      upd(24'h002000, 1, 0, "R9");
      req(2'd0, 24'h002100, "R4");
      req(2'd1, 24'h003FFF, "R5");
      req(2'd0, 24'h001FFF, "R1");
      req(2'd0, 24'h004000, "R1");
      req(2'd2, 24'h002000, "R5");
      // R5/R7: write lock on top small block 5
      upd(24'hFFA000, 0, 1, "R9");
      req(2'd0, 24'hFFA010, "R5");
      req(2'd1, 24'hFFBFFF, "R7");
      req(2'd2, 24'hFFA000, "R7");
      req(2'd1, 24'hFF9FFF, "R1");
      req(2'd1, 24'hFFC000, "R1");
      // R6/R7: big top block with both bits requested
      upd(24'hFF0000, 1, 1, "R6");
      req(2'd0, 24'hFF0100, "R6");
      req(2'd1, 24'hFF7FFF, "R7");
      req(2'd1, 24'hFEFFFF, "R1");
      // R6/R8: main block 5
      upd(24'h05ABCD, 1, 1, "R6");
      req(2'd0, 24'h050000, "R6");
      req(2'd1, 24'h05FFFF, "R7");
      req(2'd3, 24'h051234, "R8");
      req(2'd3, 24'h060000, "R8");
      // R8: low end block, single small write lock
      req(2'd3, 24'h000000, "R8");
      upd(24'h006000, 0, 1, "R9");
      req(2'd3, 24'h00F000, "R8");
      req(2'd2, 24'h00F000, "R7");
      req(2'd3, 24'hFF8000, "R8");
      // R9: same-cycle update sees old state, then new
      step(1, 24'h008000, 0, 1, 0, 1, 2'd1, 24'h008000, "R9");
      req(2'd1, 24'h008000, "R9");
      upd(24'h05FFFF, 0, 0, "R9");
      req(2'd1, 24'h050000, "R9");
      upd(24'h002000, 0, 0, "R9");
      req(2'd0, 24'h002000, "R9");
      // R10: lock-down
      step(0, '0, 0, 0, 1, 1, 2'd1, 24'h070000, "R10");
      upd(24'h070000, 0, 1, "R10");
      req(2'd1, 24'h070000, "R10");
      upd(24'hFFA000, 0, 0, "R10");
      req(2'd1, 24'hFFA000, "R10");
      upd(24'h000000, 1, 0, "R10");
      req(2'd0, 24'h000000, "R10");
      do_reset();
      req(2'd1, 24'hFFA000, "R10");
      req(2'd3, 24'h000000, "R10");
      req(2'd1, 24'h050000, "R10");
      // random phase against the model
      for (int n = 0; n < 600; n++) begin
         logic [7:0] b;
         logic [23:0] ra, ua;
         int sel = $urandom_range(0, 5);
         b = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : (sel == 2) ? 8'h01 :
             (sel == 3) ? 8'hFE : 8'(sel);
         ra = {b, 16'($urandom)};
         sel = $urandom_range(0, 5);
         b = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : (sel == 2) ? 8'h01 :
             (sel == 3) ? 8'hFE : 8'(sel);
         ua = {b, 16'($urandom)};
         step(($urandom_range(0, 3) == 0), ua, 1'($urandom), 1'($urandom), 0,
              1'($urandom_range(0, 4) != 0), 2'($urandom), ra, "R7");
      end
      step(0, '0, 0, 0, 0, 0, 2'd0, '0, "R3");
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule